// File: doc/BRIEF.md
# Accumulator Shifter with Float Normaliser

This block reduces a 32-bit signed accumulator word to a 16-bit result. It can shift the word arithmetically left or right by 0 to 15 places before the upper half is kept. It can also turn the word into an unsigned floating-point pair: a 16-bit normalised mantissa of the magnitude and a 4-bit exponent that counts the places the magnitude was moved up.

The block takes new operands on every clock. Each result is registered and appears one clock after its operands are sampled. The word source and the result destination belong to the surrounding datapath.

Top module: `acc_shift_norm`

## Requirements
- R1: While `rst_n` is low, including an assertion of `rst_n` in the middle of a run, `dout` and `exp_out` are 0 whatever the inputs are.
- R2: The result for operands sampled at a rising clock edge appears on the outputs at that edge and stays there until the next edge. The outputs do not change between edges.
- R3: With `op` = 2'b01, `dout` is bits [31:16] of `din` shifted right by `shamt`, with copies of bit 31 shifted in at the top.
- R4: With `op` = 2'b00, when the left shift by `shamt` loses no significant bit, `dout` is bits [31:16] of `din` shifted left by `shamt`, with zeros entering at the bottom.
- R5: With `op` = 2'b00, if any bit shifted out of bit 31, or the new bit 31, differs from the original bit 31 of `din`, `dout` saturates. It becomes 16'h7FFF for a non-negative `din` and 16'h8000 for a negative `din`.
- R6: With `op` = 2'b10, the exponent E is the number of leading zeros of the 32-bit magnitude of `din`, capped at 15. `dout` is bits [31:16] of the magnitude shifted left by E, and `exp_out` is E.
- R7: In float mode the magnitude of a negative `din` is its two's-complement negation, read as unsigned, so 32'h80000000 gives mantissa 16'h8000 and exponent 0.
- R8: In float mode a zero `din` gives `dout` = 0 and `exp_out` = 15.
- R9: `exp_out` is 0 after every operation other than float mode. `op` = 2'b11 acts exactly like the right shift (2'b01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 32 | Signed accumulator word |
| op | input | 2 | 00 shift left, 01 shift right, 10 float, 11 shift right |
| shamt | input | 4 | Shift distance, 0 to 15 (ignored in float mode) |
| dout | output | 16 | Shifted result or mantissa |
| exp_out | output | 4 | Float exponent, 0 for the shift operations |

## Verification
Every result, the mantissa and its exponent included, is due exactly one rising edge after its operands are presented. The bench changes the inputs on falling edges. It checks the result of the previous vector on the same falling edge, before it applies the next one, so a stream of vectors also proves the single-cycle latency. A directed test probes the outputs again just before the next rising edge, to show they have not moved early. Reset is checked while the inputs are active and again when it is asserted asynchronously in the middle of a run.

// File: rtl/acc_shift_norm.sv
module acc_shift_norm #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IN_W-1:0]            din,
  input  logic [1:0]                 op,
  input  logic [$clog2(OUT_W)-1:0]   shamt,
  output logic [OUT_W-1:0]           dout,
  output logic [$clog2(OUT_W)-1:0]   exp_out
);
  localparam int SH_W   = $clog2(OUT_W);
  localparam int EXT_W  = IN_W + OUT_W;
  localparam int MAX_SH = OUT_W - 1;
  localparam logic [1:0] OP_SHL = 2'b00;
  localparam logic [1:0] OP_FLT = 2'b10;

  logic              sgn;
  logic [IN_W-1:0]   shr_v, mag, norm;
  logic [EXT_W-1:0]  shl_v;
  logic              shl_ovf;
  logic [OUT_W-1:0]  sat_v;
  logic [SH_W-1:0]   lz;

  assign sgn     = din[IN_W-1];
  assign shr_v   = $signed(din) >>> shamt;
  assign shl_v   = {{OUT_W{sgn}}, din} << shamt;
  assign shl_ovf = shl_v[EXT_W-1:IN_W-1] != {(OUT_W+1){sgn}};
  assign sat_v   = sgn ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
  assign mag     = sgn ? (~din + 1'b1) : din;

  always_comb begin
    lz = SH_W'(MAX_SH);
    for (int i = MAX_SH - 1; i >= 0; i--)
      if (mag[IN_W-1-i]) lz = SH_W'(i);
  end

  assign norm = mag << lz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      exp_out <= '0;
    end else begin
      case (op)
        OP_SHL: begin
          dout    <= shl_ovf ? sat_v : shl_v[IN_W-1 -: OUT_W];
          exp_out <= '0;
        end
        OP_FLT: begin
          dout    <= norm[IN_W-1 -: OUT_W];
          exp_out <= lz;
        end
        default: begin
          dout    <= shr_v[IN_W-1 -: OUT_W];
          exp_out <= '0;
        end
      endcase
    end
  end

  logic chk_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) chk_ok <= 1'b0;
    else        chk_ok <= 1'b1;

  p_shift_exp_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok && $past(op) != OP_FLT |-> exp_out == '0);

  p_shift_keeps_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok && $past(op) != OP_FLT |-> dout[OUT_W-1] == $past(din[IN_W-1]));

  p_float_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok && $past(op) == OP_FLT && $past(din) == '0 |-> dout == '0 && exp_out == SH_W'(MAX_SH));

  p_float_normalised_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok && $past(op) == OP_FLT && exp_out != SH_W'(MAX_SH) |-> dout[OUT_W-1]);

  p_float_most_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok && $past(op) == OP_FLT && $past(din) == {1'b1, {(IN_W-1){1'b0}}}
    |-> dout == {1'b1, {(OUT_W-1){1'b0}}} && exp_out == '0);
endmodule

// File: tb/acc_shift_norm_tb.sv
module acc_shift_norm_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] din;
  logic [1:0]  op;
  logic [3:0]  shamt;
  logic [15:0] dout;
  logic [3:0]  exp_out;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  acc_shift_norm u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .op(op), .shamt(shamt),
    .dout(dout), .exp_out(exp_out)
  );

  // {req, op, shamt, din, dout, exp}
  localparam int NV = 20;
  localparam logic [61:0] VEC [NV] = '{
    {4'd3, 2'b01, 4'd4,  32'h12345678, 16'h0123, 4'd0},  // R3
    {4'd3, 2'b01, 4'd8,  32'h80000000, 16'hFF80, 4'd0},  // R3
    {4'd3, 2'b01, 4'd15, 32'hFFFF0000, 16'hFFFF, 4'd0},  // R3
    {4'd3, 2'b01, 4'd0,  32'hABCD1234, 16'hABCD, 4'd0},  // R3
    {4'd4, 2'b00, 4'd4,  32'h01234567, 16'h1234, 4'd0},  // R4
    {4'd4, 2'b00, 4'd15, 32'h00001234, 16'h091A, 4'd0},  // R4
    {4'd4, 2'b00, 4'd4,  32'hFFF12345, 16'hFF12, 4'd0},  // R4
    {4'd5, 2'b00, 4'd1,  32'h40000000, 16'h7FFF, 4'd0},  // R5
    {4'd5, 2'b00, 4'd4,  32'h87654321, 16'h8000, 4'd0},  // R5
    {4'd5, 2'b00, 4'd15, 32'h00010000, 16'h7FFF, 4'd0},  // R5
    {4'd4, 2'b00, 4'd0,  32'h80000000, 16'h8000, 4'd0},  // R4
    {4'd6, 2'b10, 4'd9,  32'h00010000, 16'h8000, 4'd15}, // R6
    {4'd6, 2'b10, 4'd0,  32'h00000001, 16'h0000, 4'd15}, // R6
    {4'd6, 2'b10, 4'd2,  32'h12345678, 16'h91A2, 4'd3},  // R6
    {4'd7, 2'b10, 4'd0,  32'hFFFFFF00, 16'h0080, 4'd15}, // R7
    {4'd7, 2'b10, 4'd0,  32'hC0000000, 16'h8000, 4'd1},  // R7
    {4'd7, 2'b10, 4'd7,  32'h80000000, 16'h8000, 4'd0},  // R7
    {4'd8, 2'b10, 4'd5,  32'h00000000, 16'h0000, 4'd15}, // R8
    {4'd9, 2'b11, 4'd4,  32'h87654321, 16'hF876, 4'd0},  // R9
    {4'd6, 2'b10, 4'd0,  32'h7FFFFFFF, 16'hFFFF, 4'd1}   // R6
  };

  task automatic check(input string req, input logic [15:0] ed, input logic [3:0] ee);
    n_chk++;
    if (dout !== ed || exp_out !== ee) begin
      n_bad++;
      $display("FAIL %s: dout=%h exp=%0d, expected dout=%h exp=%0d", req, dout, exp_out, ed, ee);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog: run still active, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; din = 32'h12345678; op = 2'b10; shamt = 4'd3;
    repeat (3) @(negedge clk);
    check("R1 reset with active inputs", 16'h0000, 4'd0);
    rst_n = 1'b1;

    for (int k = 0; k <= NV; k++) begin
      @(negedge clk);
      if (k > 0) begin
        logic [3:0] r; logic [1:0] vo; logic [3:0] vs; logic [31:0] vd; logic [15:0] ed; logic [3:0] ee;
        {r, vo, vs, vd, ed, ee} = VEC[k-1];
        check($sformatf("R%0d vector %0d", r, k - 1), ed, ee);
      end
      if (k < NV) {op, shamt, din} = VEC[k][57:20];
    end

    // R2: no early change, result exactly one edge later
    @(negedge clk); op = 2'b01; shamt = 4'd0; din = 32'hAAAA0000;
    @(negedge clk); check("R2 first result", 16'hAAAA, 4'd0);
    din = 32'h55550000;
    #2 check("R2 held before edge", 16'hAAAA, 4'd0);
    @(negedge clk); check("R2 next result", 16'h5555, 4'd0);

    // R1: asynchronous reset mid-run
    op = 2'b10; din = 32'h12345678;
    @(negedge clk); check("R6 before reset", 16'h91A2, 4'd3);
    #1 rst_n = 1'b0;
    #1 check("R1 async reset", 16'h0000, 4'd0);
    @(negedge clk); check("R1 held in reset", 16'h0000, 4'd0);
    rst_n = 1'b1;
    @(negedge clk); check("R6 after reset", 16'h91A2, 4'd3);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule